// File: doc/BRIEF.md
# Quad-Access Core Register File

This block is the private register store of one processor core. Software sees 512 registers of 32 bits each. In hardware the store is organised as 128 rows, and each row is 128 bits wide. Instruction operands use a 32-bit port for single-register reads and a 32-bit port for single-register writes.

A second pair of 128-bit ports moves a whole row in one access. That is four neighbouring registers. A 16-byte line can therefore pass between the core and shared memory in a single transfer slot. Both read paths have one clock of latency. Both read paths are registered.

When a quad write and a single write land in the same row in the same cycle, the quad write takes priority. A read of a row that is being written in the same cycle returns the contents from before the write.

Top module: `quad_regfile`

## Requirements
- R1: While `rst_n` is low, `rd_data` and `qrd_data` are forced to zero. They stay zero until a read is issued.
- R2: A single write stores `wr_data` at register `wr_addr`. A later single read of that address returns the value on `rd_data` one clock after `rd_en` is sampled.
- R3: Register number 4r+k lives in row r, in bits [32k+31:32k] of that row. Address bits [8:2] pick the row and bits [1:0] pick the lane, so the lowest-numbered register of a row occupies bits [31:0].
- R4: A single write changes only its own 32-bit lane. The other three registers of the row keep their values.
- R5: A quad write stores all 128 bits of `qwr_data` into row `qwr_row` in one access. Afterwards each of the four registers reads back its slice.
- R6: A quad read of row `qrd_row` returns the four registers of that row on `qrd_data` one clock after `qrd_en` is sampled.
- R7: A single write and a quad write may target the same row in the same cycle. In that case the single write is discarded and the row holds exactly `qwr_data`. When the two writes target different rows, both take effect.
- R8: A single or quad read of a location that is written in the same cycle returns the value held before that write.
- R9: `rd_data` holds its value while `rd_en` is low, and `qrd_data` holds its value while `qrd_en` is low. This is true even when the addressed storage changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the read registers |
| rd_en | input | 1 | Single-register read request |
| rd_addr | input | 9 | Register address for the single read |
| rd_data | output | 32 | Single read result, one clock after the request |
| wr_en | input | 1 | Single-register write request |
| wr_addr | input | 9 | Register address for the single write |
| wr_data | input | 32 | Single write data |
| qrd_en | input | 1 | Quad read request |
| qrd_row | input | 7 | Row for the quad read |
| qrd_data | output | 128 | Quad read result, one clock after the request |
| qwr_en | input | 1 | Quad write request |
| qwr_row | input | 7 | Row for the quad write |
| qwr_data | input | 128 | Quad write data, lowest register in bits [31:0] |

## Verification
The hardest cases to reach from the ports are the ones where several accesses meet in one cycle. These include a single write and a quad write hitting the same row, once for each of the four lanes. They also include either read port observing a row at the same edge that it is being written. The stimulus builds these collisions on purpose after the whole store has been filled with known, address-dependent values. It then reads the affected row back through both the quad port and the single port, so that a dropped or misplaced lane shows up at the outputs. A fill-and-sweep of every register and every row checks the lane layout exhaustively.

// File: rtl/qrf_pkg.sv
package qrf_pkg;
  // Row that holds a given logical register.
  function automatic int row_of(input int addr, input int lanes);
    return addr / lanes;
  endfunction

  // Lane inside the row that holds a given logical register.
  function automatic int lane_of(input int addr, input int lanes);
    return addr % lanes;
  endfunction
endpackage

// File: rtl/qrf_wr_ctrl.sv
module qrf_wr_ctrl #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned ROW_AW = 7,
  parameter int unsigned LSEL_W = 2
) (
  input  logic              wr_en,
  input  logic [ROW_AW-1:0] wr_row,
  input  logic [LSEL_W-1:0] wr_lane,
  input  logic              qwr_en,
  input  logic [ROW_AW-1:0] qwr_row,
  output logic [LANES-1:0]  single_we,
  output logic [LANES-1:0]  quad_we,
  output logic              single_drop
);
  // The quad write covers every lane of its row, so a single write into that row loses.
  assign single_drop = wr_en && qwr_en && (wr_row == qwr_row);

  for (genvar k = 0; k < LANES; k++) begin : g_lane_en
    assign single_we[k] = wr_en && !single_drop && (wr_lane == LSEL_W'(k));
    assign quad_we[k]   = qwr_en;
  end
endmodule

// File: rtl/qrf_lane.sv
module qrf_lane #(
  parameter int unsigned ROWS   = 128,
  parameter int unsigned ROW_AW = 7,
  parameter int unsigned W      = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_we,
  input  logic [ROW_AW-1:0] s_wrow,
  input  logic [W-1:0]      s_wdata,
  input  logic              q_we,
  input  logic [ROW_AW-1:0] q_wrow,
  input  logic [W-1:0]      q_wdata,
  input  logic              s_re,
  input  logic [ROW_AW-1:0] s_rrow,
  input  logic              q_re,
  input  logic [ROW_AW-1:0] q_rrow,
  output logic [W-1:0]      s_rdata,
  output logic [W-1:0]      q_rdata
);
  logic [W-1:0] mem [ROWS];

  // Two write ports. Write controls never enable both on the same row at once.
  always_ff @(posedge clk) begin
    if (s_we) mem[s_wrow] <= s_wdata;
    if (q_we) mem[q_wrow] <= q_wdata;
  end

  // Registered reads sample the array before this edge's writes land.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_rdata <= '0;
      q_rdata <= '0;
    end else begin
      if (s_re) s_rdata <= mem[s_rrow];
      if (q_re) q_rdata <= mem[q_rrow];
    end
  end
endmodule

// File: rtl/quad_regfile.sv
module quad_regfile #(
  parameter int unsigned ROWS   = 128,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 32,
  localparam int unsigned REGS   = ROWS * LANES,
  localparam int unsigned REG_AW = $clog2(REGS),
  localparam int unsigned ROW_AW = $clog2(ROWS),
  localparam int unsigned LSEL_W = $clog2(LANES),
  localparam int unsigned QUAD_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [REG_AW-1:0] rd_addr,
  output logic [LANE_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [LANE_W-1:0] wr_data,
  input  logic              qrd_en,
  input  logic [ROW_AW-1:0] qrd_row,
  output logic [QUAD_W-1:0] qrd_data,
  input  logic              qwr_en,
  input  logic [ROW_AW-1:0] qwr_row,
  input  logic [QUAD_W-1:0] qwr_data
);
  // Named internal events, also observed by the checker.
  logic [ROW_AW-1:0] rd_row, wr_row;
  logic [LSEL_W-1:0] rd_lane, wr_lane, rd_lane_q;
  logic [LANES-1:0]  single_we, quad_we;
  logic              single_drop;
  logic [LANE_W-1:0] lane_sdata [LANES];
  logic [LANE_W-1:0] lane_qdata [LANES];

  assign rd_row  = ROW_AW'(qrf_pkg::row_of(int'(rd_addr), LANES));
  assign rd_lane = LSEL_W'(qrf_pkg::lane_of(int'(rd_addr), LANES));
  assign wr_row  = ROW_AW'(qrf_pkg::row_of(int'(wr_addr), LANES));
  assign wr_lane = LSEL_W'(qrf_pkg::lane_of(int'(wr_addr), LANES));

  qrf_wr_ctrl #(.LANES(LANES), .ROW_AW(ROW_AW), .LSEL_W(LSEL_W)) u_wr_ctrl (
    .wr_en      (wr_en),
    .wr_row     (wr_row),
    .wr_lane    (wr_lane),
    .qwr_en     (qwr_en),
    .qwr_row    (qwr_row),
    .single_we  (single_we),
    .quad_we    (quad_we),
    .single_drop(single_drop)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    qrf_lane #(.ROWS(ROWS), .ROW_AW(ROW_AW), .W(LANE_W)) u_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .s_we   (single_we[k]),
      .s_wrow (wr_row),
      .s_wdata(wr_data),
      .q_we   (quad_we[k]),
      .q_wrow (qwr_row),
      .q_wdata(qwr_data[k*LANE_W +: LANE_W]),
      .s_re   (rd_en),
      .s_rrow (rd_row),
      .q_re   (qrd_en),
      .q_rrow (qrd_row),
      .s_rdata(lane_sdata[k]),
      .q_rdata(lane_qdata[k])
    );
    assign qrd_data[k*LANE_W +: LANE_W] = lane_qdata[k];
  end

  // Lane select travels alongside the registered row read.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_lane_q <= '0;
    else if (rd_en) rd_lane_q <= rd_lane;
  end

  assign rd_data = lane_sdata[rd_lane_q];
endmodule

// File: rtl/qrf_checker.sv
module qrf_checker #(
  parameter int unsigned ROWS   = 128,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 32,
  localparam int unsigned REG_AW = $clog2(ROWS * LANES),
  localparam int unsigned ROW_AW = $clog2(ROWS),
  localparam int unsigned LSEL_W = $clog2(LANES),
  localparam int unsigned QUAD_W = LANES * LANE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en,
  input logic [LANE_W-1:0] rd_data,
  input logic              qrd_en,
  input logic [QUAD_W-1:0] qrd_data,
  input logic              wr_en,
  input logic [REG_AW-1:0] wr_addr,
  input logic              qwr_en,
  input logic [ROW_AW-1:0] qwr_row,
  input logic [LANES-1:0]  single_we,
  input logic [LANES-1:0]  quad_we,
  input logic              single_drop
);
  a_r1_reset_zero: assert property (@(posedge clk)
    !rst_n |=> (rd_data == '0 && qrd_data == '0));

  a_r9_single_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

  a_r9_quad_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !qrd_en |=> $stable(qrd_data));

  a_r7_quad_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && qwr_en && wr_addr[REG_AW-1:LSEL_W] == qwr_row) |-> (single_drop && single_we == '0));

  a_r4_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(single_we));

  a_r4_lane_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !single_drop) |-> single_we[wr_addr[LSEL_W-1:0]]);

  a_r5_quad_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    qwr_en |-> ($countones(quad_we) == LANES));
endmodule

bind quad_regfile qrf_checker #(.ROWS(ROWS), .LANES(LANES), .LANE_W(LANE_W)) u_qrf_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_en      (rd_en),
  .rd_data    (rd_data),
  .qrd_en     (qrd_en),
  .qrd_data   (qrd_data),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .qwr_en     (qwr_en),
  .qwr_row    (qwr_row),
  .single_we  (single_we),
  .quad_we    (quad_we),
  .single_drop(single_drop)
);

// File: tb/test_quad_regfile.sv
`timescale 1ns/1ps
module test_quad_regfile;
  localparam int NREG = 512;
  localparam int NROW = 128;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         rd_en = 1'b0, wr_en = 1'b0, qrd_en = 1'b0, qwr_en = 1'b0;
  logic [8:0]   rd_addr = '0, wr_addr = '0;
  logic [31:0]  wr_data = '0;
  logic [6:0]   qrd_row = '0, qwr_row = '0;
  logic [127:0] qwr_data = '0;
  logic [31:0]  rd_data;
  logic [127:0] qrd_data;

  logic [31:0] model [NREG];
  int vectors = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  quad_regfile i_quad_regfile (
    .clk(clk), .rst_n(rst_n),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .qrd_en(qrd_en), .qrd_row(qrd_row), .qrd_data(qrd_data),
    .qwr_en(qwr_en), .qwr_row(qwr_row), .qwr_data(qwr_data)
  );

  function automatic logic [31:0] pat(input int a, input logic [31:0] seed);
    logic [31:0] x = 32'(a);
    return (x * 32'h9E37_79B1) ^ seed ^ {x[15:0], 16'h0};
  endfunction

  // R3 layout: register 4r+k sits at bits [32k+31:32k].
  function automatic logic [127:0] row_img(input int r);
    return {model[4*r+3], model[4*r+2], model[4*r+1], model[4*r]};
  endfunction

  task automatic chk32(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk128(input string req, input logic [127:0] act, input logic [127:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic idle();
    rd_en = 1'b0; wr_en = 1'b0; qrd_en = 1'b0; qwr_en = 1'b0;
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic [31:0]  old32;
    logic [127:0] old128, q;
    // R1 reset state
    cyc(); cyc(); cyc();
    chk32("R1 rd_data reset", rd_data, 32'h0);
    chk128("R1 qrd_data reset", qrd_data, 128'h0);
    rst_n = 1'b1;
    cyc();
    chk32("R1 rd_data after release", rd_data, 32'h0);

    // Fill every register through the single port (R2)
    for (int a = 0; a < NREG; a++) begin
      wr_en = 1'b1; wr_addr = 9'(a); wr_data = pat(a, 32'hA5A5_0F0F);
      model[a] = wr_data;
      cyc();
    end
    idle();

    // R6/R3: quad read every row
    for (int r = 0; r < NROW; r++) begin
      qrd_en = 1'b1; qrd_row = 7'(r);
      cyc();
      chk128("R6 R3 quad read row", qrd_data, row_img(r));
    end
    idle();

    // R2: single read every register
    for (int a = 0; a < NREG; a++) begin
      rd_en = 1'b1; rd_addr = 9'(a);
      cyc();
      chk32("R2 single read", rd_data, model[a]);
    end
    idle();

    // R5: quad write every row, read back by single reads
    for (int r = 0; r < NROW; r++) begin
      qwr_en = 1'b1; qwr_row = 7'(r);
      for (int k = 0; k < 4; k++) begin
        model[4*r+k] = pat(4*r+k, 32'h3C3C_C3C3);
        qwr_data[32*k +: 32] = model[4*r+k];
      end
      cyc();
    end
    idle();
    for (int a = 0; a < NREG; a++) begin
      rd_en = 1'b1; rd_addr = 9'(a);
      cyc();
      chk32("R5 lane of quad write", rd_data, model[a]);
    end
    idle();

    // R4: one single write per row, other lanes must be untouched
    for (int r = 0; r < NROW; r++) begin
      wr_en = 1'b1; wr_addr = 9'(4*r + (r % 4)); wr_data = pat(r, 32'h0BAD_F00D);
      model[4*r + (r % 4)] = wr_data;
      cyc();
      idle();
      qrd_en = 1'b1; qrd_row = 7'(r);
      cyc();
      chk128("R4 other lanes kept", qrd_data, row_img(r));
      idle();
    end

    // R7: same-row collision, every lane
    for (int k = 0; k < 4; k++) begin
      wr_en = 1'b1; wr_addr = 9'(36 + k); wr_data = 32'hDEAD_0000 + 32'(k);
      qwr_en = 1'b1; qwr_row = 7'd9;
      q = {32'h9000_0003 + 32'(k), 32'h9000_0002, 32'h9000_0001, 32'h9000_0000 + 32'(k)};
      qwr_data = q;
      for (int j = 0; j < 4; j++) model[36+j] = q[32*j +: 32];
      cyc();
      idle();
      qrd_en = 1'b1; qrd_row = 7'd9; rd_en = 1'b1; rd_addr = 9'(36 + k);
      cyc();
      chk128("R7 quad wins row", qrd_data, row_img(9));
      chk32("R7 single dropped", rd_data, model[36+k]);
      idle();
    end
    // R7: different rows, both writes land
    wr_en = 1'b1; wr_addr = 9'd81; wr_data = 32'h1234_5678; model[81] = wr_data;
    qwr_en = 1'b1; qwr_row = 7'd21; qwr_data = {4{32'hCAFE_BEEF}};
    for (int j = 0; j < 4; j++) model[84+j] = 32'hCAFE_BEEF;
    cyc();
    idle();
    qrd_en = 1'b1; qrd_row = 7'd21; rd_en = 1'b1; rd_addr = 9'd81;
    cyc();
    chk128("R7 distinct rows quad", qrd_data, row_img(21));
    chk32("R7 distinct rows single", rd_data, model[81]);
    idle();

    // R8: read during write returns old value
    old32 = model[50];
    rd_en = 1'b1; rd_addr = 9'd50;
    wr_en = 1'b1; wr_addr = 9'd50; wr_data = 32'h5555_AAAA; model[50] = wr_data;
    cyc();
    chk32("R8 single old data", rd_data, old32);
    idle();
    rd_en = 1'b1; rd_addr = 9'd50;
    cyc();
    chk32("R8 single new data", rd_data, model[50]);
    idle();
    old128 = row_img(30);
    qrd_en = 1'b1; qrd_row = 7'd30;
    qwr_en = 1'b1; qwr_row = 7'd30; qwr_data = {32'h4, 32'h3, 32'h2, 32'h1};
    for (int j = 0; j < 4; j++) model[120+j] = 32'(j + 1);
    cyc();
    chk128("R8 quad old data", qrd_data, old128);
    idle();
    old128 = row_img(31);
    qrd_en = 1'b1; qrd_row = 7'd31;
    wr_en = 1'b1; wr_addr = 9'd125; wr_data = 32'h7777_7777; model[125] = wr_data;
    cyc();
    chk128("R8 quad old during single write", qrd_data, old128);
    idle();
    qrd_en = 1'b1; qrd_row = 7'd30;
    cyc();
    chk128("R8 quad new data", qrd_data, row_img(30));
    idle();

    // R9: outputs hold while read enables are low
    rd_en = 1'b1; rd_addr = 9'd7; qrd_en = 1'b1; qrd_row = 7'd2;
    cyc();
    old32 = rd_data; old128 = qrd_data;
    idle();
    rd_addr = 9'd8; qrd_row = 7'd3;
    wr_en = 1'b1; wr_addr = 9'd7; wr_data = 32'hFFFF_0001; model[7] = wr_data;
    cyc();
    idle();
    qwr_en = 1'b1; qwr_row = 7'd2; qwr_data = '1;
    cyc();
    idle();
    cyc();
    chk32("R9 single hold", rd_data, old32);
    chk128("R9 quad hold", qrd_data, old128);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule